// File: doc/BRIEF.md
# Grouped Interrupt Priority Arbiter

This block picks one interrupt line from a set of pending request lines and decides whether that line may interrupt the handler that is running now. Each line has an 8-bit priority value and an enable bit, both held in a small table that a simple write port loads. A smaller priority value is more urgent, and values compare as unsigned numbers. A 3-bit split setting divides every priority value into two parts. The upper part is the group field and the lower part is the subpriority field.

To choose a winner, the block compares the group field first, then the subpriority field, and then the line number. The lowest line number wins a full tie. Preemption looks only at the group field. A winner whose group field equals the running handler's group field stays pending. This holds whatever its subpriority or line number. The winning line number, a valid flag and a preempt-request flag leave the block from registers. So a change at the inputs shows at the outputs one clock later.

Top module: `gipa_arbiter`

## Requirements
- R1: While reset is applied and right after it, `irq_valid`, `preempt_req` and `irq_id` are all 0. After reset every line is disabled.
- R2: A line takes part in arbitration only if it is both pending and enabled. If no line qualifies, `irq_valid` is 0, `irq_id` is 0 and `preempt_req` is 0.
- R3: Among the qualifying lines, the one with the numerically smallest 8-bit priority value is selected. Values compare as unsigned numbers.
- R4: If qualifying lines share a group field, the line with the smaller subpriority field is selected.
- R5: If qualifying lines have identical priority values, the line with the lowest line number is selected.
- R6: When `in_handler` is 0, every valid selection raises `preempt_req`.
- R7: When `in_handler` is 1, `preempt_req` is 1 only if the winner's group field is strictly smaller than the group field of `active_prio`. An equal group field never preempts, and the subpriority bits of either value do not matter.
- R8: With `split_cfg` = N, the group field is bits [7:N+1] and the subpriority field is bits [N:0]. With N = 7 the group field is empty, so no interrupt preempts a running handler.
- R9: The outputs are registered. A change on `pending`, `split_cfg`, `in_handler` or `active_prio` shows at the outputs after exactly one rising clock edge.
- R10: A write with `wr_en` = 1 stores `wr_prio` and `wr_enable` for line `wr_idx` at the clock edge. The new entry reaches the outputs one edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; its release is synchronized inside the block |
| pending | input | NUM_IRQ | Level-sensitive request lines, one bit per line |
| wr_en | input | 1 | Write strobe for the priority table |
| wr_idx | input | IDX_W | Line whose table entry is written |
| wr_prio | input | 8 | Priority value to store |
| wr_enable | input | 1 | Enable bit to store |
| split_cfg | input | 3 | Split point N: group field is bits [7:N+1] |
| in_handler | input | 1 | A handler is running now |
| active_prio | input | 8 | Priority value of the running handler; only its group field is used |
| irq_id | output | IDX_W | Number of the selected line, 0 when nothing is selected |
| irq_valid | output | 1 | A qualifying line was selected |
| preempt_req | output | 1 | The selected line may interrupt the running handler |

## Verification
The hardest case to reach is the one where a pending line's subpriority is better than the running handler's, yet no preemption may follow. To reach it, the stimulus holds `in_handler` high and uses an active priority and winners that share one group field but differ in their low bits. It then moves the winner's group field one step either side. It also changes `split_cfg` while the table stays unchanged. This shows that the same pair of values can cross the group boundary under one split and stay inside it under another. Ties on the full priority value are set up between lines at both ends of the selection tree, and the lower-numbered line is then removed so the other one takes over.

// File: rtl/gipa_pkg.sv
package gipa_pkg;

  localparam int GIPA_PRIO_W  = 8;
  localparam int GIPA_SPLIT_W = 3;

  typedef logic [GIPA_PRIO_W-1:0]  prio_t;
  typedef logic [GIPA_SPLIT_W-1:0] split_t;

  // Bits of a priority value that form the group field for split n.
  function automatic prio_t group_mask(input split_t n);
    logic [31:0] ones;
    ones = {32{1'b1}} << (32'(n) + 32'd1);
    return prio_t'(ones);
  endfunction

endpackage

// File: rtl/gipa_rst_sync.sv
module gipa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/gipa_prio_table.sv
module gipa_prio_table #(
  parameter int NUM_IRQ = 16,
  parameter int IDX_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  gipa_pkg::prio_t     wr_prio,
  input  logic                wr_enable,
  output gipa_pkg::prio_t     prio_o [NUM_IRQ],
  output logic [NUM_IRQ-1:0]  en_o
);

  gipa_pkg::prio_t    prio_q [NUM_IRQ];
  gipa_pkg::prio_t    prio_d [NUM_IRQ];
  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] en_d;
  logic [NUM_IRQ-1:0] line_ce;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign line_ce[i] = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      prio_d[i] = prio_q[i];
      en_d[i]   = en_q[i];
      if (line_ce[i]) begin
        prio_d[i] = wr_prio;
        en_d[i]   = wr_enable;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
        en_q[i]   <= 1'b0;
      end else if (line_ce[i]) begin
        prio_q[i] <= prio_d[i];
        en_q[i]   <= en_d[i];
      end
    end

    assign prio_o[i] = prio_q[i];
  end

  assign en_o = en_q;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R10: a write lands in the addressed entry at the next edge
  assert_table_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && wr_en) |=> (prio_o[$past(wr_idx)] == $past(wr_prio)) &&
                           (en_o[$past(wr_idx)] == $past(wr_enable)));

endmodule

// File: rtl/gipa_min_tree.sv
module gipa_min_tree #(
  parameter int NUM_IRQ = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_IRQ-1:0] cand_v,
  input  gipa_pkg::prio_t    cand_p [NUM_IRQ],
  output logic               win_v,
  output gipa_pkg::prio_t    win_p,
  output logic [IDX_W-1:0]   win_id
);

  localparam int LVLS = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 0;
  localparam int NP   = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int N = NP >> l;
    logic            v  [N];
    gipa_pkg::prio_t p  [N];
    logic [IDX_W-1:0] id [N];

    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_in
        if (i < NUM_IRQ) begin : g_real
          assign v[i]  = cand_v[i];
          assign p[i]  = cand_p[i];
          assign id[i] = IDX_W'(i);
        end else begin : g_pad
          assign v[i]  = 1'b0;
          assign p[i]  = '1;
          assign id[i] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < N; j++) begin : g_cmp
        logic take_left;
        // The left child holds the lower line numbers, so it wins ties.
        assign take_left = g_lvl[l-1].v[2*j] &&
                           (!g_lvl[l-1].v[2*j+1] ||
                            (g_lvl[l-1].p[2*j] <= g_lvl[l-1].p[2*j+1]));
        assign v[j]  = g_lvl[l-1].v[2*j] || g_lvl[l-1].v[2*j+1];
        assign p[j]  = take_left ? g_lvl[l-1].p[2*j]  : g_lvl[l-1].p[2*j+1];
        assign id[j] = take_left ? g_lvl[l-1].id[2*j] : g_lvl[l-1].id[2*j+1];
      end
    end
  end

  assign win_v  = g_lvl[LVLS].v[0];
  assign win_p  = g_lvl[LVLS].p[0];
  assign win_id = g_lvl[LVLS].id[0];

endmodule

// File: rtl/gipa_preempt.sv
module gipa_preempt (
  input  logic            win_v,
  input  gipa_pkg::prio_t win_p,
  input  gipa_pkg::prio_t active_p,
  input  logic            in_handler,
  input  gipa_pkg::split_t split,
  output logic            preempt
);

  gipa_pkg::prio_t gmask;
  gipa_pkg::prio_t win_grp;
  gipa_pkg::prio_t act_grp;
  logic            grp_better;

  always_comb begin
    gmask      = gipa_pkg::group_mask(split);
    win_grp    = win_p & gmask;
    act_grp    = active_p & gmask;
    grp_better = win_grp < act_grp;
    preempt    = win_v && (!in_handler || grp_better);
  end

endmodule

// File: rtl/gipa_arbiter.sv
module gipa_arbiter #(
  parameter  int NUM_IRQ = 16,
  localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pending,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_prio,
  input  logic               wr_enable,
  input  logic [2:0]         split_cfg,
  input  logic               in_handler,
  input  logic [7:0]         active_prio,
  output logic [IDX_W-1:0]   irq_id,
  output logic               irq_valid,
  output logic               preempt_req
);

  logic               rst_s_n;
  gipa_pkg::prio_t    prio_tab [NUM_IRQ];
  logic [NUM_IRQ-1:0] en_vec;
  logic [NUM_IRQ-1:0] cand;
  logic               win_v;
  gipa_pkg::prio_t    win_p;
  logic [IDX_W-1:0]   win_id;
  logic               pre_c;

  gipa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  gipa_prio_table #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_tab (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_prio   (wr_prio),
    .wr_enable (wr_enable),
    .prio_o    (prio_tab),
    .en_o      (en_vec)
  );

  assign cand = pending & en_vec;

  gipa_min_tree #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_tree (
    .cand_v (cand),
    .cand_p (prio_tab),
    .win_v  (win_v),
    .win_p  (win_p),
    .win_id (win_id)
  );

  gipa_preempt u_pre (
    .win_v      (win_v),
    .win_p      (win_p),
    .active_p   (active_prio),
    .in_handler (in_handler),
    .split      (split_cfg),
    .preempt    (pre_c)
  );

  logic             valid_d, valid_q;
  logic             pre_d, pre_q;
  logic [IDX_W-1:0] id_d, id_q;

  always_comb begin
    valid_d = win_v;
    pre_d   = pre_c;
    id_d    = win_v ? win_id : '0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      valid_q <= 1'b0;
      pre_q   <= 1'b0;
      id_q    <= '0;
    end else begin
      valid_q <= valid_d;
      pre_q   <= pre_d;
      id_q    <= id_d;
    end
  end

  assign irq_valid   = valid_q;
  assign preempt_req = pre_q;
  assign irq_id      = id_q;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) armed_q <= 1'b0;
    else          armed_q <= 1'b1;
  end

  // R3/R5: the root of the tree beats or ties every qualifying leaf
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    assert_min_select_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
      cand[i] |-> win_v && ((win_p < prio_tab[i]) ||
                            ((win_p == prio_tab[i]) && (win_id <= IDX_W'(i)))));
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !irq_valid |-> (!preempt_req && (irq_id == '0)));

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    armed_q |=> (irq_valid == $past(|(pending & en_vec))));

  assert_thread_preempt_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (armed_q && !in_handler && win_v) |=> preempt_req);

  assert_same_group_hold_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (armed_q && in_handler &&
     ((win_p & gipa_pkg::group_mask(split_cfg)) ==
      (active_prio & gipa_pkg::group_mask(split_cfg)))) |=> !preempt_req);

  assert_empty_group_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (armed_q && in_handler && (split_cfg == 3'd7)) |=> !preempt_req);

endmodule

// File: tb/sim_gipa_arbiter.sv
module sim_gipa_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ    = 16;
  localparam int IDX_W      = 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_IRQ-1:0] pending;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [7:0]         wr_prio;
  logic               wr_enable;
  logic [2:0]         split_cfg;
  logic               in_handler;
  logic [7:0]         active_prio;
  logic [IDX_W-1:0]   irq_id;
  logic               irq_valid;
  logic               preempt_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gipa_arbiter #(.NUM_IRQ(NUM_IRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .pending(pending), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_prio(wr_prio), .wr_enable(wr_enable),
    .split_cfg(split_cfg), .in_handler(in_handler), .active_prio(active_prio),
    .irq_id(irq_id), .irq_valid(irq_valid), .preempt_req(preempt_req)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input int v, input int id, input int pre);
    chk(req, "irq_valid", int'(irq_valid), v);
    chk(req, "irq_id", int'(irq_id), id);
    chk(req, "preempt_req", int'(preempt_req), pre);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input int prio, input bit en);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_prio = 8'(prio); wr_enable = en;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    pending = '0; in_handler = 1'b0; active_prio = 8'hFF; split_cfg = 3'd3;
    for (int i = 0; i < NUM_IRQ; i++) wr(i, 8'hFF, 1'b0);
    settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pending = '1; wr_en = 1'b0; wr_idx = '0; wr_prio = '0;
    wr_enable = 1'b0; split_cfg = 3'd3; in_handler = 1'b0; active_prio = 8'hFF;
    #(CLK_PERIOD*2 + 1);
    chk_out("R1", 0, 0, 0);                     // R1: during reset
    @(negedge clk); rst_n = 1'b1;
    repeat (4) settle();
    chk_out("R1", 0, 0, 0);                     // R1: all lines disabled after reset
  endtask

  task automatic t_masking();
    clear_all();
    pending = '1; settle();
    chk_out("R2", 0, 0, 0);                     // R2: pending but disabled
    wr(3, 8'h40, 1'b1);
    pending = 16'h0020; settle();
    chk_out("R2", 0, 0, 0);                     // R2: enabled but not pending
    pending = 16'h0028; settle();
    chk_out("R2", 1, 3, 1);
  endtask

  task automatic t_overall_min();
    clear_all();
    wr(2, 8'h80, 1'b1); wr(9, 8'h20, 1'b1); wr(12, 8'h60, 1'b1);
    pending = 16'h1204; settle();
    chk_out("R3", 1, 9, 1);                     // R3: smallest value wins
    pending = 16'h1004; settle();
    chk_out("R3", 1, 12, 1);
  endtask

  task automatic t_subprio();
    clear_all();
    wr(4, 8'h37, 1'b1); wr(6, 8'h31, 1'b1);
    pending = 16'h0050; settle();
    chk("R4", "irq_id", int'(irq_id), 6);       // R4: same group, better sub
  endtask

  task automatic t_index_tie();
    clear_all();
    wr(0, 8'h50, 1'b1); wr(7, 8'h50, 1'b1); wr(11, 8'h50, 1'b1); wr(15, 8'h50, 1'b1);
    pending = 16'h8880; settle();
    chk("R5", "irq_id", int'(irq_id), 7);       // R5: lowest number on full tie
    pending = 16'h8800; settle();
    chk("R5", "irq_id", int'(irq_id), 11);
    pending = 16'h8881; settle();
    chk("R5", "irq_id", int'(irq_id), 0);
  endtask

  task automatic t_latency();
    clear_all();
    wr(1, 8'h10, 1'b1); wr(2, 8'h20, 1'b1);
    pending = 16'h0004; settle();
    chk("R9", "irq_id", int'(irq_id), 2);
    pending = 16'h0006; #1;
    chk("R9", "irq_id before edge", int'(irq_id), 2); // R9: not yet updated
    settle();
    chk("R9", "irq_id after edge", int'(irq_id), 1);
  endtask

  task automatic t_thread_preempt();
    clear_all();
    wr(5, 8'hFE, 1'b1);
    pending = 16'h0020; in_handler = 1'b0; settle();
    chk_out("R6", 1, 5, 1);                     // R6: no handler running
  endtask

  task automatic t_nested();
    clear_all();
    wr(4, 8'h31, 1'b1); wr(5, 8'h30, 1'b1); wr(6, 8'h2F, 1'b1); wr(8, 8'h40, 1'b1);
    split_cfg = 3'd3; in_handler = 1'b1; active_prio = 8'h35;
    pending = 16'h0010; settle();
    chk_out("R7", 1, 4, 0);                     // R7: equal group, better sub
    pending = 16'h0030; settle();
    chk_out("R7", 1, 5, 0);
    pending = 16'h0070; settle();
    chk_out("R7", 1, 6, 1);                     // R7: group 2 beats group 3
    pending = 16'h0100; settle();
    chk_out("R7", 1, 8, 0);                     // R7: worse group
  endtask

  task automatic t_split();
    clear_all();
    wr(4, 8'h31, 1'b1);
    in_handler = 1'b1; active_prio = 8'h35; pending = 16'h0010;
    split_cfg = 3'd1; settle();
    chk("R8", "preempt split1", int'(preempt_req), 1); // R8: groups 12 vs 13
    split_cfg = 3'd3; settle();
    chk("R8", "preempt split3", int'(preempt_req), 0);
    wr(4, 8'h00, 1'b1); active_prio = 8'hFF;
    split_cfg = 3'd7; settle();
    chk("R8", "preempt split7", int'(preempt_req), 0); // R8: empty group field
    split_cfg = 3'd6; settle();
    chk("R8", "preempt split6", int'(preempt_req), 1);
  endtask

  task automatic t_write();
    clear_all();
    wr(3, 8'h20, 1'b1); wr(9, 8'h10, 1'b1);
    pending = 16'h0208; settle();
    chk("R10", "irq_id", int'(irq_id), 9);
    wr(9, 8'h10, 1'b0);
    chk("R10", "irq_id at write edge", int'(irq_id), 9); // R10: not yet visible
    settle();
    chk("R10", "irq_id after disable", int'(irq_id), 3);
    wr(3, 8'h90, 1'b1); wr(9, 8'h80, 1'b1); settle();
    chk("R10", "irq_id after rewrite", int'(irq_id), 9);
  endtask

  initial begin
    t_reset();
    t_masking();
    t_overall_min();
    t_subprio();
    t_index_tie();
    t_latency();
    t_thread_preempt();
    t_nested();
    t_split();
    t_write();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule